// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block collects ten interrupt request lines, picks the one that the CPU should service next, and gives the CPU a request flag and a fixed vector address for it. Each source has an enable bit and a level-select bit. A global enable gates every source. The CPU answers a request with an acknowledge pulse and ends each handler with a return strobe.

There are three service levels: top, high and low. Only the first two sources can be raised to the top level; the other eight can be raised only to high. The arbiter keeps one in-service bit for each level. A new request is taken only when its level is strictly above the highest level now in service. A handler can therefore be interrupted by a handler of a higher level, and nesting can reach three deep. When several requests are eligible at once, the highest level wins. Among requests at the same level, the source with the lower index (and so the lower vector address) wins.

The arbitration result is registered. The request flag and the vector then stay frozen until the CPU acknowledges them, so the CPU can read the address at its own pace.

Top module: `vic3_arbiter`

## Requirements
- R1: During and right after reset, `irq_req` is 0, `vec_addr` reads 0x0003 and no level is in service.
- R2: The vector for source index i (0 to 9) is 0x0003 + 8*i, so the addresses run 0x0003, 0x000B, and so on up to 0x004B.
- R3: When `lvl_sel[i]` is 1, source 0 or 1 runs at top level and sources 2 to 9 run at high level. When `lvl_sel[i]` is 0, the source runs at low level. The order of the levels is top > high > low.
- R4: Among eligible requests the highest level wins. A tie on level goes to the lowest source index.
- R5: A pending request can win only while both its `src_en` bit and `glb_en` are 1. A request that is blocked stays pending and is taken once the enables are set.
- R6: A 1 sampled on `irq_in[i]` at a clock edge sets that source's pending bit. The bit stays set until that source is acknowledged, even after the line falls.
- R7: Once `irq_req` is 1, it stays 1 and `vec_addr` stays unchanged until a cycle with `cpu_ack` = 1. A higher-level request that arrives in the meantime does not replace it.
- R8: If `cpu_ack` is 1 while `irq_req` is 1, then at that edge the granted source's pending bit clears, its level is marked in service, and `irq_req` is 0 from the next cycle on. If `cpu_ack` is 1 while `irq_req` is 0, it has no effect.
- R9: A request whose level is equal to or lower than the highest in-service level is not granted.
- R10: A request whose level is strictly above the highest in-service level is granted while that handler runs, so low, high and top can all be in service at once.
- R11: A `reti` pulse clears the highest in-service level. Requests that were held off become eligible again as the levels unwind.
- R12: If the granted source's line is still high in the acknowledge cycle, its pending bit still clears. That cycle's input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 10 | Request lines, one per source |
| lvl_sel | input | 10 | Raises each source to its upper level when 1 |
| src_en | input | 10 | Per-source enable |
| glb_en | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | CPU takes the offered vector |
| reti | input | 1 | Handler return; clears the highest in-service level |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector address of the granted source |

## Verification
On every cycle the assertions check the following. A raised request holds its vector until it is acknowledged. An acknowledge drops the request on the next cycle. A granted level is always above the highest in-service level. Each acknowledge adds exactly one in-service level. A pending bit never disappears without its own clear. The vector is always on the 8-byte grid. Other behaviour can only be shown by the bench scenarios, which run against a behavioural reference model: which source wins a tie or a level contest, how a held-off request is released as `reti` unwinds the nesting, how the enables gate requests, and whether a stray acknowledge or a line still high at acknowledge has any effect.

// File: rtl/vic3_pkg.sv
package vic3_pkg;

   // Service levels, ordered so that a larger value means more urgent
   typedef enum logic [1:0] {
      LV_NONE = 2'd0,
      LV_LOW  = 2'd1,
      LV_HIGH = 2'd2,
      LV_TOP  = 2'd3
   } lvl_e;

   localparam int unsigned NUM_LEVELS = 3;

endpackage

// File: rtl/vic3_pending.sv
// Per-source pending latch: set by the line, cleared only by its own acknowledge
module vic3_pending #(
   parameter int unsigned N_SRC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] line_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);

   logic [N_SRC-1:0] pend_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q[i] <= 1'b0;
         else if (clr_i[i])
            pend_q[i] <= 1'b0;   // clear beats a line still high (R12)
         else if (line_i[i])
            pend_q[i] <= 1'b1;
      end
   end

   assign pend_o = pend_q;

   // R6: a pending bit survives every cycle in which it is not cleared
   p_pend_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_q & ~clr_i) & ~pend_q) == '0));

endmodule

// File: rtl/vic3_inservice.sv
// In-service level record: one bit per level, pop clears the highest one
module vic3_inservice
   import vic3_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  lvl_e push_lvl_i,
   input  logic pop_i,
   output lvl_e cur_lvl_o
);

   localparam int unsigned NL = NUM_LEVELS;

   logic [NL-1:0] isr_q, isr_d, top_mask, push_bit;

   always_comb begin
      top_mask = '0;
      for (int k = 0; k < int'(NL); k++)
         if (isr_q[k]) top_mask = NL'(1) << k;   // last set bit = highest
   end

   always_comb begin
      unique case (push_lvl_i)
         LV_LOW:  push_bit = 3'b001;
         LV_HIGH: push_bit = 3'b010;
         LV_TOP:  push_bit = 3'b100;
         default: push_bit = 3'b000;
      endcase
   end

   always_comb begin
      isr_d = isr_q;
      if (pop_i)  isr_d = isr_d & ~top_mask;
      if (push_i) isr_d = isr_d | push_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   always_comb begin
      if (isr_q[2])      cur_lvl_o = LV_TOP;
      else if (isr_q[1]) cur_lvl_o = LV_HIGH;
      else if (isr_q[0]) cur_lvl_o = LV_LOW;
      else               cur_lvl_o = LV_NONE;
   end

   // R10: a pushed level is always above everything already in service
   p_push_above_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (push_lvl_i > cur_lvl_o));

   // R10: an acknowledge without a return adds exactly one level
   p_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

   // R11: a return alone removes exactly one level when any is active
   p_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && (isr_q != '0)) |=>
         ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

// File: rtl/vic3_select.sv
// Combinational contest: highest level wins, lowest index breaks ties
module vic3_select
   import vic3_pkg::*;
#(
   parameter int unsigned N_SRC = 10,
   parameter int unsigned N_TOP = 2,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] pend_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic             glb_en_i,
   input  logic [N_SRC-1:0] raise_i,
   input  lvl_e             cur_lvl_i,
   output logic             found_o,
   output logic [IDX_W-1:0] win_o,
   output lvl_e             win_lvl_o
);

   lvl_e             src_lvl [N_SRC];
   logic [N_SRC-1:0] elig;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i < N_TOP) begin : g_top_capable
         assign src_lvl[i] = raise_i[i] ? LV_TOP : LV_LOW;
      end else begin : g_high_capable
         assign src_lvl[i] = raise_i[i] ? LV_HIGH : LV_LOW;
      end
      assign elig[i] = pend_i[i] & en_i[i] & glb_en_i & (src_lvl[i] > cur_lvl_i);
   end

   always_comb begin
      win_lvl_o = LV_NONE;
      win_o     = '0;
      for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
         if (elig[i] && (src_lvl[i] >= win_lvl_o)) begin
            win_lvl_o = src_lvl[i];
            win_o     = IDX_W'(i);
         end
      end
   end

   assign found_o = (win_lvl_o != LV_NONE);

endmodule

// File: rtl/vic3_arbiter.sv
// Three-level vectored interrupt arbiter, top level
module vic3_arbiter
   import vic3_pkg::*;
#(
   parameter int unsigned N_SRC    = 10,
   parameter int unsigned N_TOP    = 2,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic [N_SRC-1:0]  lvl_sel,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              glb_en,
   input  logic              cpu_ack,
   input  logic              reti,
   output logic              irq_req,
   output logic [ADDR_W-1:0] vec_addr
);

   localparam int unsigned IDX_W    = $clog2(N_SRC);
   localparam longint      VEC_LAST = longint'(VEC_BASE) + longint'(VEC_STEP) * (N_SRC - 1);

   // Elaboration-time parameter checks
   if (N_SRC < 2) begin : g_chk_nsrc
      $error("vic3_arbiter: N_SRC must be at least 2");
   end
   if (N_TOP > N_SRC) begin : g_chk_ntop
      $error("vic3_arbiter: N_TOP cannot exceed N_SRC");
   end
   if (VEC_STEP == 0) begin : g_chk_step
      $error("vic3_arbiter: VEC_STEP must be non-zero");
   end
   if (VEC_LAST >= (longint'(1) << ADDR_W)) begin : g_chk_addr
      $error("vic3_arbiter: vector table does not fit in ADDR_W bits");
   end

   logic [N_SRC-1:0] pend, clr;
   lvl_e             cur_lvl, win_lvl, lvl_q;
   logic             found, req_q, ack_fire;
   logic [IDX_W-1:0] win, sel_q;

   assign ack_fire = cpu_ack & req_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_clr
      assign clr[i] = ack_fire && (sel_q == IDX_W'(i));
   end

   vic3_pending #(.N_SRC(N_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (irq_in),
      .clr_i  (clr),
      .pend_o (pend)
   );

   vic3_inservice u_isr (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (ack_fire),
      .push_lvl_i (lvl_q),
      .pop_i      (reti),
      .cur_lvl_o  (cur_lvl)
   );

   vic3_select #(.N_SRC(N_SRC), .N_TOP(N_TOP)) u_sel (
      .pend_i    (pend),
      .en_i      (src_en),
      .glb_en_i  (glb_en),
      .raise_i   (lvl_sel),
      .cur_lvl_i (cur_lvl),
      .found_o   (found),
      .win_o     (win),
      .win_lvl_o (win_lvl)
   );

   // Grant register: loads only while idle, then holds until acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         sel_q <= '0;
         lvl_q <= LV_NONE;
      end else if (req_q) begin
         if (cpu_ack) req_q <= 1'b0;
      end else if (found) begin
         req_q <= 1'b1;
         sel_q <= win;
         lvl_q <= win_lvl;
      end
   end

   assign irq_req  = req_q;
   assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(sel_q);

   // R7: an offered vector is frozen until acknowledged
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !cpu_ack) |=> (irq_req && $stable(vec_addr)));

   // R8: acknowledge withdraws the request on the next cycle
   p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && cpu_ack) |=> !irq_req);

   // R9: an offered request always outranks the in-service level
   p_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (lvl_q > cur_lvl));

   // R5: a request only rises after the global enable was set
   p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(glb_en));

   // R2: the vector lies on the table grid
   p_vec_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (((int'(vec_addr) - int'(VEC_BASE)) % int'(VEC_STEP)) == 0 &&
                   longint'(vec_addr) <= VEC_LAST));

endmodule

// File: tb/vic3_arbiter_tb.sv
module vic3_arbiter_tb;

   localparam int N = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic [N-1:0] lvl_sel = 10'h22D;   // raised: sources 0,2,3,5,9
   logic [N-1:0] src_en = '1;
   logic        glb_en = 1'b1;
   logic        cpu_ack = 1'b0;
   logic        reti = 1'b0;
   logic        irq_req;
   logic [15:0] vec_addr;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #4 clk = ~clk;   // 125 MHz

   vic3_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_sel(lvl_sel),
      .src_en(src_en), .glb_en(glb_en), .cpu_ack(cpu_ack), .reti(reti),
      .irq_req(irq_req), .vec_addr(vec_addr)
   );

   // ---------------- behavioural reference model ----------------
   bit m_pend [N];
   int stk [$];
   bit m_req;
   int m_sel;
   int m_lvl;

   function automatic int lvl_of(int i);
      if (!lvl_sel[i]) return 1;
      return (i < 2) ? 3 : 2;
   endfunction

   always @(posedge clk) begin : model
      int cur, w, wl;
      bit ackf;
      if (!rst_n) begin
         foreach (m_pend[i]) m_pend[i] = 0;
         stk.delete();
         m_req = 0; m_sel = 0; m_lvl = 0;
      end else begin
         cur  = (stk.size() > 0) ? stk[stk.size()-1] : 0;
         ackf = cpu_ack && m_req;
         w = -1; wl = 0;
         if (!m_req)
            for (int lv = 3; lv >= 1; lv--)
               for (int i = 0; i < N; i++)
                  if (w < 0 && m_pend[i] && src_en[i] && glb_en &&
                      lvl_of(i) == lv && lv > cur) begin
                     w = i; wl = lv;
                  end
         for (int i = 0; i < N; i++)
            m_pend[i] = (m_pend[i] || irq_in[i]) && !(ackf && i == m_sel);
         if (reti && stk.size() > 0) void'(stk.pop_back());
         if (ackf) stk.push_back(m_lvl);
         if (m_req) begin
            if (cpu_ack) m_req = 0;
         end else if (w >= 0) begin
            m_req = 1; m_sel = w; m_lvl = wl;
         end
      end
   end

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (R4 ordering, R2 addresses)
   always @(negedge clk) begin
      if (rst_n) begin
         check(irq_req == m_req, "R4", "model irq_req", int'(irq_req), int'(m_req));
         check(vec_addr == 16'(3 + 8 * m_sel), "R2", "model vec_addr",
               int'(vec_addr), 3 + 8 * m_sel);
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic pulse(logic [N-1:0] m);
      @(negedge clk) irq_in = m;
      @(negedge clk) irq_in = '0;
   endtask

   task automatic do_ack();
      @(negedge clk) cpu_ack = 1'b1;
      @(negedge clk) cpu_ack = 1'b0;
      check(irq_req == 1'b0, "R8", "irq_req after ack", int'(irq_req), 0);
   endtask

   task automatic do_reti();
      @(negedge clk) reti = 1'b1;
      @(negedge clk) reti = 1'b0;
   endtask

   task automatic expect_grant(int exp, string tag);
      int waited = 0;
      while (!irq_req && waited < 8) begin
         @(negedge clk);
         waited++;
      end
      check(irq_req == 1'b1, tag, "grant raised", int'(irq_req), 1);
      check(vec_addr == 16'(exp), tag, "granted vector", int'(vec_addr), exp);
   endtask

   task automatic expect_idle(int n, string tag);
      bit seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq_req) seen = 1;
      end
      check(!seen, tag, "request held off", int'(seen), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(irq_req == 1'b0, "R1", "irq_req in reset", int'(irq_req), 0);
      check(vec_addr == 16'h0003, "R1", "vec_addr in reset", int'(vec_addr), 3);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_req == 1'b0, "R1", "irq_req after reset", int'(irq_req), 0);

      // R6, R2: one-cycle pulse on a low source is latched and served
      pulse(10'b00_0001_0000);
      expect_grant(16'h0023, "R6");
      do_ack();

      // R9: low in service, another low waits
      pulse(10'b00_0100_0000);
      expect_idle(6, "R9");
      // R10: high preempts low, then top preempts high
      pulse(10'b00_0000_1000);
      expect_grant(16'h001B, "R10");
      do_ack();
      pulse(10'b00_0000_0001);
      expect_grant(16'h0003, "R10");
      do_ack();
      // R11: unwinding releases the waiting low request only at the end
      do_reti();
      expect_idle(4, "R11");
      do_reti();
      expect_idle(4, "R11");
      do_reti();
      expect_grant(16'h0033, "R11");
      do_ack();
      do_reti();

      // R4: equal high levels, lowest index wins; low waits
      pulse(10'b00_1010_0100);
      expect_grant(16'h0013, "R4");
      do_ack(); do_reti();
      expect_grant(16'h002B, "R4");
      do_ack(); do_reti();
      expect_grant(16'h003B, "R4");
      do_ack(); do_reti();

      // R3: top-capable source beats high; high beats low
      pulse(10'b00_0000_0101);
      expect_grant(16'h0003, "R3");
      do_ack(); do_reti();
      expect_grant(16'h0013, "R3");
      do_ack(); do_reti();
      pulse(10'b10_0000_0010);
      expect_grant(16'h004B, "R3");
      do_ack(); do_reti();
      expect_grant(16'h000B, "R3");
      do_ack(); do_reti();

      // R3/R9: source 9 raised is high, not top: blocked by high in service
      pulse(10'b00_0000_1000);
      expect_grant(16'h001B, "R9");
      do_ack();
      pulse(10'b10_0000_0000);
      expect_idle(6, "R3");
      do_reti();
      expect_grant(16'h004B, "R9");
      do_ack(); do_reti();

      // R5: source enable and global enable gate the contest
      src_en[8] = 1'b0;
      pulse(10'b01_0000_0000);
      expect_idle(6, "R5");
      @(negedge clk) src_en[8] = 1'b1;
      expect_grant(16'h0043, "R5");
      do_ack(); do_reti();
      glb_en = 1'b0;
      pulse(10'b00_0000_1000);
      expect_idle(6, "R5");
      @(negedge clk) glb_en = 1'b1;
      expect_grant(16'h001B, "R5");
      do_ack(); do_reti();

      // R7: offered vector is not replaced by a later top request
      pulse(10'b10_0000_0000);
      expect_grant(16'h004B, "R7");
      pulse(10'b00_0000_0001);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(irq_req && vec_addr == 16'h004B, "R7", "held vector",
               int'(vec_addr), 16'h004B);
      end
      do_ack();
      expect_grant(16'h0003, "R7");
      do_ack(); do_reti(); do_reti();

      // R8: acknowledge with nothing offered changes nothing
      do_ack();
      pulse(10'b00_0001_0000);
      expect_grant(16'h0023, "R8");
      do_ack(); do_reti();

      // R12: line still high at acknowledge; pending clears anyway
      @(negedge clk) irq_in = 10'b00_0100_0000;
      expect_grant(16'h0033, "R12");
      cpu_ack = 1'b1;
      @(negedge clk) begin cpu_ack = 1'b0; irq_in = '0; end
      do_reti();
      expect_idle(6, "R12");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule